// File: doc/BRIEF.md
# Floating-Point Error Ignore Handshake

This block sits between a processor's active-low floating-point error signal and the legacy interrupt logic. When the error line falls and the error-routing enable is set, the block raises a request on the IRQ13 line. That request stays up until software acknowledges it by writing to a dedicated 8-bit I/O port. Any data value counts as the acknowledgement. The write then drives an active-low ignore-error signal back to the processor, so the processor can resume past the faulting instruction.

The ignore signal stays asserted until the processor releases its error line. Reads of the port always return zero, so the port carries no storage. The error line is asynchronous, so it passes through a synchronizer chain before its edges are detected.

Top module: `fpe_ignore_ctl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `irq13` is 0 and `ignore_n` is 1.
- R2: `io_rdata` is 8'h00 at all times. This holds during reads of the port at address 16'h00F0 and after any value has been written there.
- R3: With `err_en` = 1, a falling edge on `fp_err_n` sets `irq13` to 1 on the third rising clock edge after the fall. Two edges go to the synchronizer and one to the edge register, and `irq13` is still 0 after the second edge.
- R4: With `err_en` = 0, a falling edge on `fp_err_n` leaves `irq13` at 0.
- R5: A write (`io_wr` = 1) to address 16'h00F0, with any data value including 8'h00, while `irq13` is 1 and `err_en` is 1, drives `ignore_n` to 0 and `irq13` to 0 at that clock edge.
- R6: A write to 16'h00F0 while `irq13` is 0, or while `err_en` is 0, leaves `ignore_n` at 1.
- R7: A write to any address other than 16'h00F0, or a read of 16'h00F0, leaves both `ignore_n` and `irq13` unchanged.
- R8: A rising edge on `fp_err_n` returns `ignore_n` to 1 and clears a pending `irq13` on the third rising clock edge after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data (value ignored) |
| io_rdata | output | 8 | Read data, always zero |
| fp_err_n | input | 1 | Asynchronous floating-point error from the processor, active low |
| err_en | input | 1 | Enables routing the error to IRQ13 |
| irq13 | output | 1 | Pending interrupt request |
| ignore_n | output | 1 | Ignore-error to the processor, active low |

## Verification
The hardest case to reach is a port write that lands while a request is pending. It has to be told apart from writes that arrive before the synchronized edge has registered, and from writes made while the enable is low. The bench walks the error line down, counts exactly three edges to reach the pending state, and then sends the write. It also sends writes to a neighbouring address and reads to the port while the request is still pending. It releases the error line without a write, to show that the request drops without an acknowledgement.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] PORT_ADDR = 16'h00F0;
  localparam logic [DATA_W-1:0] RD_VALUE  = '0;

  function automatic logic addr_match(input logic [ADDR_W-1:0] a);
    return a == PORT_ADDR;
  endfunction

  function automatic logic edge_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic edge_rise(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction
endpackage

// File: rtl/fpe_sync.sv
module fpe_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fpe_port_dec.sv
module fpe_port_dec
  import fpe_pkg::*;
(
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic [DATA_W-1:0] io_rdata
);
  assign wr_hit   = io_wr & addr_match(io_addr);
  assign rd_hit   = io_rd & addr_match(io_addr);
  assign io_rdata = rd_hit ? RD_VALUE : '0;
endmodule

// File: rtl/fpe_handshake.sv
module fpe_handshake
  import fpe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic err_s,
  input  logic err_en,
  input  logic wr_hit,
  output logic irq13,
  output logic ignore_n
);
  logic err_d, pend_q, ign_q;
  logic err_fall, err_rise, grant;

  assign err_fall = edge_fall(err_d, err_s);
  assign err_rise = edge_rise(err_d, err_s);
  assign grant    = wr_hit & pend_q & err_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_d  <= 1'b1;
      pend_q <= 1'b0;
      ign_q  <= 1'b1;
    end else begin
      err_d <= err_s;
      if (grant | err_rise) pend_q <= 1'b0;
      else if (err_fall & err_en) pend_q <= 1'b1;
      if (err_rise) ign_q <= 1'b1;
      else if (grant) ign_q <= 1'b0;
    end
  end

  assign irq13    = pend_q;
  assign ignore_n = ign_q;

  // R3
  irq_from_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq13) |-> $past(err_fall));
  // R4
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq13) |-> $past(err_en));
  // R5
  ignore_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ignore_n) |-> $past(wr_hit && pend_q && err_en));
  // R5
  ignore_excl_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !ignore_n |-> !irq13);
  // R8
  release_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ignore_n) |-> $past(err_rise));
endmodule

// File: rtl/fpe_ignore_ctl.sv
module fpe_ignore_ctl
  import fpe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              fp_err_n,
  input  logic              err_en,
  output logic              irq13,
  output logic              ignore_n
);
  logic err_s, wr_hit, rd_hit;
  logic wdata_unused;
  assign wdata_unused = ^io_wdata;

  fpe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(fp_err_n), .q(err_s));

  fpe_port_dec u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .io_rdata(io_rdata));

  fpe_handshake u_hs (
    .clk(clk), .rst(rst), .err_s(err_s), .err_en(err_en),
    .wr_hit(wr_hit), .irq13(irq13), .ignore_n(ignore_n));

  // R2
  read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit || wdata_unused || !wdata_unused) |-> io_rdata == 8'h00);
endmodule

// File: tb/fpe_ignore_ctl_test.sv
module fpe_ignore_ctl_test;
  logic clk = 0, rst = 1;
  logic [15:0] io_addr = 16'h0000;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic fp_err_n = 1, err_en = 0;
  logic irq13, ignore_n;

  always #2.5 clk = ~clk;

  fpe_ignore_ctl uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .fp_err_n(fp_err_n),
    .err_en(err_en), .irq13(irq13), .ignore_n(ignore_n));

  typedef struct {
    logic irq;
    logic ign;
    logic [7:0] rd;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic expect_now(input logic irq, input logic ign, input string tag);
    exp_t e;
    e.irq = irq; e.ign = ign; e.rd = 8'h00; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic port_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic port_read(input logic [15:0] a);
    io_addr = a; io_rd = 1;
    @(negedge clk);
    io_rd = 0;
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (irq13 !== e.irq || ignore_n !== e.ign || io_rdata !== e.rd) begin
          fails++;
          $display("FAIL %s: irq13=%b ignore_n=%b rdata=%h expected irq13=%b ignore_n=%b rdata=%h",
                   e.tag, irq13, ignore_n, io_rdata, e.irq, e.ign, e.rd);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst = 0;
    cycles(1);
    expect_now(0, 1, "R1 reset state");

    // R3 latency with enable set
    err_en = 1;
    fp_err_n = 0;
    cycles(2);
    expect_now(0, 1, "R3 no irq after two edges");
    cycles(1);
    expect_now(1, 1, "R3 irq after three edges");

    // R7 read and wrong address write do nothing; R2 read value
    port_read(16'h00F0);
    expect_now(1, 1, "R2 R7 read of port");
    port_write(16'h00F1, 8'hFF);
    expect_now(1, 1, "R7 write to other address");

    // R5 acknowledge
    port_write(16'h00F0, 8'h5A);
    expect_now(0, 0, "R5 write acknowledges");
    port_read(16'h00F0);
    expect_now(0, 0, "R2 read after write");

    // R8 release
    fp_err_n = 1;
    cycles(2);
    expect_now(0, 0, "R8 still ignoring after two edges");
    cycles(1);
    expect_now(0, 1, "R8 release after three edges");

    // R6 write with nothing pending
    port_write(16'h00F0, 8'h33);
    expect_now(0, 1, "R6 write without pending");

    // R4 enable low
    err_en = 0;
    fp_err_n = 0;
    cycles(4);
    expect_now(0, 1, "R4 no irq when disabled");
    port_write(16'h00F0, 8'h11);
    expect_now(0, 1, "R6 write when disabled");
    fp_err_n = 1;
    cycles(4);

    // R5 zero data also acknowledges
    err_en = 1;
    fp_err_n = 0;
    cycles(3);
    expect_now(1, 1, "R3 irq again");
    port_write(16'h00F0, 8'h00);
    expect_now(0, 0, "R5 zero data acknowledges");
    fp_err_n = 1;
    cycles(3);
    expect_now(0, 1, "R8 release again");

    // R8 rise without write clears pending
    fp_err_n = 0;
    cycles(3);
    expect_now(1, 1, "R3 pending set");
    fp_err_n = 1;
    cycles(3);
    expect_now(0, 1, "R8 rise clears pending");

    // R6 enable dropped while pending
    fp_err_n = 0;
    cycles(3);
    err_en = 0;
    port_write(16'h00F0, 8'h77);
    expect_now(1, 1, "R6 write ignored with enable low");
    err_en = 1;

    // R1 reset while pending
    rst = 1;
    cycles(1);
    rst = 0;
    expect_now(0, 1, "R1 reset clears pending");
    fp_err_n = 1;
    cycles(4);
    expect_now(0, 1, "R1 idle after reset");

    cycles(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule